// File: doc/BRIEF.md
# CAN Bit-Stream Error Detector

This block watches a CAN bit stream one bit time at a time and flags protocol violations. An external frame sequencer tells it which part of the frame the current bit belongs to through a field code. On each sample strobe the block takes the sampled bus level, the level this node is driving and a flag saying whether the node is the transmitter. From these it updates five sticky error flags: CRC, stuffing, bit, form and acknowledge. It also raises an error-frame request for the next bit time and keeps a transmit and a receive error counter. A combined bus-drive output tells the transceiver when to pull the line dominant, either for the node's own transmitted bits or for the acknowledge bit it gives as a receiver.

A listen-only autobaud control puts the node into a passive mode. While software adjusts the bit timing, the error flags keep reporting what the line looks like. In this mode the counters do not move, the node drives nothing and it never acknowledges. Clearing the control returns the block to normal operation at once.

Top module: `can_err_detect`

## Requirements
- R1: After reset all five error flags, the error-frame request, the bus-drive output and both counters are 0.
- R2: Field codes 1 (start of frame), 2 (arbitration), 3 (control/data) and 4 (CRC sequence) form the stuffed region. A run count restarts at the start-of-frame bit. When five equal levels have been sampled, the next bit in the stuffed region is a stuff bit if it has the opposite level. If it has the same level, a stuff error is flagged.
- R3: When the node transmits (and autobaud is off) in any field other than idle (code 0), a mismatch between the driven and the sampled level is a bit error. In arbitration (code 2) and in the ACK slot (code 6), only driving recessive (1) while sampling dominant (0) is allowed; driving dominant while sampling recessive is still a bit error.
- R4: A dominant (0) sample in the CRC delimiter (code 5), the ACK delimiter (code 7) or end of frame (code 8) sets the form error flag.
- R5: The CRC is 15 bits wide with polynomial 0x4599. The register is cleared to zero and then updated with the start-of-frame bit. Every following non-stuff bit of codes 2 to 4 is shifted in, MSB first. A nonzero remainder at the CRC delimiter sample sets the CRC error flag.
- R6: A transmitting node (autobaud off) that samples recessive in the ACK slot sets the acknowledge error flag.
- R7: A stuff, bit, form or acknowledge error found at a strobe raises the error-frame request from the next clock. The request holds until the next strobe. A CRC error alone does not raise it.
- R8: Error flags are sticky and clear on a one-cycle clear pulse. If a flag is detected in the same cycle as the clear pulse, the detection wins.
- R9: With autobaud off, a strobe that detects any error adds 8 to the transmit counter if the node is transmitting, or adds 1 to the receive counter otherwise. This happens once per strobe, however many flags are raised. Both counters saturate and change only on strobes.
- R10: With autobaud on, the bus-drive output stays 0, no bit or acknowledge error is raised, and both counters hold their values. The other flags keep updating. Clearing autobaud restores normal counting and driving.
- R11: The bus-drive output is 1 when the node transmits a dominant bit. It is also 1 in the ACK slot when the node is a receiver and the last CRC check since start of frame passed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sample_i | input | 1 | One-cycle strobe at the sample point of a bit time |
| rx_bit_i | input | 1 | Sampled bus level, 0 = dominant |
| tx_bit_i | input | 1 | Level the node drives this bit, 0 = dominant |
| transmitting_i | input | 1 | Node is the transmitter of the current frame |
| field_i | input | 4 | Frame field code from the sequencer |
| autobaud_i | input | 1 | Listen-only autobaud mode |
| clr_i | input | 1 | Clear pulse for the error flags |
| err_crc_o | output | 1 | Sticky CRC error |
| err_stuff_o | output | 1 | Sticky stuff error |
| err_bit_o | output | 1 | Sticky bit error |
| err_form_o | output | 1 | Sticky form error |
| err_ack_o | output | 1 | Sticky acknowledge error |
| errframe_req_o | output | 1 | Start an error frame this bit time |
| bus_dom_o | output | 1 | Drive the bus dominant |
| tec_o | output | 9 | Transmit error counter |
| rec_o | output | 8 | Receive error counter |

## Verification
The clear pulse and a new detection can land in the same cycle. The bench provokes this with a strobe that carries a dominant ACK-delimiter bit, issued while an older stuff flag is still set. It expects the old flag to be cleared and the new form flag to be set. The CRC check and the form check also share the CRC-delimiter strobe. A vector samples dominant there after a corrupt CRC and expects both flags, a single counter step and an error-frame request.

// File: rtl/can_err_pkg.sv
// Package: shared field codes and helpers for the CAN error detector.
// Assumes the frame sequencer encodes fields with these 4-bit values.
package can_err_pkg;

    localparam int FIELD_W = 4;

    typedef enum logic [FIELD_W-1:0] {
        FLD_IDLE      = 4'd0,
        FLD_SOF       = 4'd1,
        FLD_ARB       = 4'd2,
        FLD_CTRL_DATA = 4'd3,
        FLD_CRC_SEQ   = 4'd4,
        FLD_CRC_DELIM = 4'd5,
        FLD_ACK_SLOT  = 4'd6,
        FLD_ACK_DELIM = 4'd7,
        FLD_EOF       = 4'd8
    } fld_e;

    // Flag slot positions in the detection vector
    localparam int F_CRC   = 0;
    localparam int F_STUFF = 1;
    localparam int F_BIT   = 2;
    localparam int F_FORM  = 3;
    localparam int F_ACK   = 4;
    localparam int N_FLAGS = 5;

    // True for fields after SOF that carry stuffing
    function automatic logic in_stuffed(input fld_e f);
        return (f == FLD_ARB) || (f == FLD_CTRL_DATA) || (f == FLD_CRC_SEQ);
    endfunction

    // True for fixed-form recessive fields
    function automatic logic in_fixed(input fld_e f);
        return (f == FLD_CRC_DELIM) || (f == FLD_ACK_DELIM) || (f == FLD_EOF);
    endfunction

endpackage

// File: rtl/can_stuff_mon.sv
// Module: tracks runs of equal levels in the stuffed region.
// Flags the bit after LIMIT equal levels as a stuff bit (opposite level)
// or as a stuff error (same level). Assumes sof_i marks the first bit.
module can_stuff_mon #(
    parameter int LIMIT = 5
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sample_i,
    input  logic bit_i,
    input  logic sof_i,
    input  logic region_i,
    output logic stuff_bit_o,
    output logic stuff_err_o
);
    localparam int CW = $clog2(LIMIT + 1);
    localparam logic [CW-1:0] LIM_V = CW'(LIMIT);

    logic [CW-1:0] run_q;
    logic          last_q;
    logic          at_limit;

    // Decide whether the current bit is a stuff bit or a violation
    always_comb begin
        at_limit    = region_i && (run_q == LIM_V);
        stuff_bit_o = at_limit && (bit_i != last_q);
        stuff_err_o = at_limit && (bit_i == last_q);
    end

    // Update run length and last level on each strobe
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_q  <= '0;
            last_q <= 1'b1;
        end else if (sample_i) begin
            if (sof_i || (region_i && (at_limit || bit_i != last_q))) begin
                run_q  <= CW'(1);
                last_q <= bit_i;
            end else if (region_i) begin
                run_q  <= run_q + CW'(1);
            end
        end
    end
endmodule

// File: rtl/can_crc.sv
// Module: serial CRC register, MSB first, restarted by init_i.
// Assumes callers gate en_i with the strobe and exclude stuff bits.
module can_crc #(
    parameter int             W    = 15,
    parameter logic [W-1:0]   POLY = 15'h4599
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         en_i,
    input  logic         init_i,
    input  logic         bit_i,
    output logic [W-1:0] crc_o
);
    logic [W-1:0] base;
    logic         fb;
    logic [W-1:0] nxt;

    // One LFSR step from either zero or the held value
    always_comb begin
        base = init_i ? '0 : crc_o;
        fb   = bit_i ^ base[W-1];
        nxt  = {base[W-2:0], 1'b0} ^ (fb ? POLY : '0);
    end

    // Hold the remainder between strobes
    always_ff @(posedge clk) begin
        if (!rst_n)    crc_o <= '0;
        else if (en_i) crc_o <= nxt;
    end
endmodule

// File: rtl/can_err_cnt.sv
// Module: saturating error counter that adds STEP on each inc_i.
module can_err_cnt #(
    parameter int W    = 8,
    parameter int STEP = 1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         inc_i,
    output logic [W-1:0] cnt_o
);
    localparam logic [W-1:0] MAX_V  = '1;
    localparam logic [W-1:0] STEP_V = W'(STEP);

    // Add the step, clamping at the top value
    always_ff @(posedge clk) begin
        if (!rst_n)     cnt_o <= '0;
        else if (inc_i) cnt_o <= (cnt_o > MAX_V - STEP_V) ? MAX_V : cnt_o + STEP_V;
    end
endmodule

// File: rtl/can_err_detect.sv
// Module: CAN protocol error detector, top level.
// Evaluates one bit per sample strobe against the sequencer's field code,
// keeps sticky flags, an error-frame request, bus drive and error counters.
// Assumes strobes are single-cycle and inputs are stable while sample_i is high.
module can_err_detect
    import can_err_pkg::*;
#(
    parameter int           TEC_W       = 9,
    parameter int           REC_W       = 8,
    parameter int           TEC_STEP    = 8,
    parameter int           REC_STEP    = 1,
    parameter int           CRC_W       = 15,
    parameter logic [14:0]  CRC_POLY    = 15'h4599,
    parameter int           STUFF_LIMIT = 5
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               sample_i,
    input  logic               rx_bit_i,
    input  logic               tx_bit_i,
    input  logic               transmitting_i,
    input  logic [FIELD_W-1:0] field_i,
    input  logic               autobaud_i,
    input  logic               clr_i,
    output logic               err_crc_o,
    output logic               err_stuff_o,
    output logic               err_bit_o,
    output logic               err_form_o,
    output logic               err_ack_o,
    output logic               errframe_req_o,
    output logic               bus_dom_o,
    output logic [TEC_W-1:0]   tec_o,
    output logic [REC_W-1:0]   rec_o
);
    fld_e               fld;
    logic               is_sof, region, tx_eff;
    logic               stuff_bit, stuff_err;
    logic [CRC_W-1:0]   crc;
    logic               crc_good_q;
    logic [N_FLAGS-1:0] det, flag_q;
    logic               any_det;

    // Decode field and effective transmit role
    always_comb begin
        fld    = fld_e'(field_i);
        is_sof = (fld == FLD_SOF);
        region = in_stuffed(fld);
        tx_eff = transmitting_i && !autobaud_i;
    end

    can_stuff_mon #(.LIMIT(STUFF_LIMIT)) u_stuff (
        .clk         (clk),
        .rst_n       (rst_n),
        .sample_i    (sample_i),
        .bit_i       (rx_bit_i),
        .sof_i       (is_sof),
        .region_i    (region),
        .stuff_bit_o (stuff_bit),
        .stuff_err_o (stuff_err)
    );

    can_crc #(.W(CRC_W), .POLY(CRC_POLY[CRC_W-1:0])) u_crc (
        .clk    (clk),
        .rst_n  (rst_n),
        .en_i   (sample_i && (is_sof || (region && !stuff_bit && !stuff_err))),
        .init_i (is_sof),
        .bit_i  (rx_bit_i),
        .crc_o  (crc)
    );

    // Per-strobe detection of the five error kinds
    always_comb begin
        det          = '0;
        det[F_CRC]   = sample_i && (fld == FLD_CRC_DELIM) && (crc != '0);
        det[F_STUFF] = sample_i && stuff_err;
        if (fld == FLD_ARB || fld == FLD_ACK_SLOT)
            det[F_BIT] = sample_i && tx_eff && !tx_bit_i && rx_bit_i;
        else
            det[F_BIT] = sample_i && tx_eff && (fld != FLD_IDLE) && (tx_bit_i != rx_bit_i);
        det[F_FORM]  = sample_i && in_fixed(fld) && !rx_bit_i;
        det[F_ACK]   = sample_i && tx_eff && (fld == FLD_ACK_SLOT) && rx_bit_i;
        any_det      = |det;
    end

    // Sticky flags: detection wins over the clear pulse
    for (genvar g = 0; g < N_FLAGS; g++) begin : g_flag
        always_ff @(posedge clk) begin
            if (!rst_n)      flag_q[g] <= 1'b0;
            else if (det[g]) flag_q[g] <= 1'b1;
            else if (clr_i)  flag_q[g] <= 1'b0;
        end
    end

    // Error-frame request held from one strobe to the next
    always_ff @(posedge clk) begin
        if (!rst_n)
            errframe_req_o <= 1'b0;
        else if (sample_i)
            errframe_req_o <= det[F_STUFF] | det[F_BIT] | det[F_FORM] | det[F_ACK];
    end

    // Remember the CRC verdict for the acknowledge bit
    always_ff @(posedge clk) begin
        if (!rst_n)                               crc_good_q <= 1'b0;
        else if (sample_i && is_sof)              crc_good_q <= 1'b0;
        else if (sample_i && fld == FLD_CRC_DELIM) crc_good_q <= (crc == '0);
    end

    can_err_cnt #(.W(TEC_W), .STEP(TEC_STEP)) u_tec (
        .clk   (clk),
        .rst_n (rst_n),
        .inc_i (any_det && tx_eff),
        .cnt_o (tec_o)
    );

    can_err_cnt #(.W(REC_W), .STEP(REC_STEP)) u_rec (
        .clk   (clk),
        .rst_n (rst_n),
        .inc_i (any_det && !transmitting_i && !autobaud_i),
        .cnt_o (rec_o)
    );

    // Bus drive: own dominant bits, or receiver acknowledge
    always_comb begin
        bus_dom_o = (tx_eff && !tx_bit_i) ||
                    ((fld == FLD_ACK_SLOT) && !transmitting_i && !autobaud_i && crc_good_q);
        err_crc_o   = flag_q[F_CRC];
        err_stuff_o = flag_q[F_STUFF];
        err_bit_o   = flag_q[F_BIT];
        err_form_o  = flag_q[F_FORM];
        err_ack_o   = flag_q[F_ACK];
    end
endmodule

// File: rtl/can_err_detect_chk.sv
// Checker: temporal properties of the CAN error detector, bound to the top.
module can_err_detect_chk
    import can_err_pkg::*;
(
    input logic               clk,
    input logic               rst_n,
    input logic               sample_i,
    input logic               rx_bit_i,
    input logic               tx_bit_i,
    input logic               transmitting_i,
    input logic [FIELD_W-1:0] field_i,
    input logic               autobaud_i,
    input logic               clr_i,
    input logic               err_crc_o,
    input logic               err_stuff_o,
    input logic               err_bit_o,
    input logic               err_form_o,
    input logic               err_ack_o,
    input logic               errframe_req_o,
    input logic               bus_dom_o,
    input logic [8:0]         tec_o,
    input logic [7:0]         rec_o
);
    assert_bit_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (sample_i && !autobaud_i && transmitting_i && field_i == FLD_CTRL_DATA &&
         tx_bit_i != rx_bit_i) |=> err_bit_o);

    // also covers R7
    assert_form_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (sample_i && !rx_bit_i && (field_i == FLD_CRC_DELIM || field_i == FLD_ACK_DELIM ||
         field_i == FLD_EOF)) |=> (err_form_o && errframe_req_o));

    assert_ack_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (sample_i && !autobaud_i && transmitting_i && rx_bit_i && field_i == FLD_ACK_SLOT)
        |=> err_ack_o);

    assert_req_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !sample_i |=> $stable(errframe_req_o));

    assert_stuff_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (err_stuff_o && !clr_i) |=> err_stuff_o);

    assert_crc_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (err_crc_o && !clr_i) |=> err_crc_o);

    assert_cnt_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !sample_i |=> ($stable(tec_o) && $stable(rec_o)));

    assert_ab_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
        autobaud_i |-> !bus_dom_o);

    assert_ab_freeze_R10: assert property (@(posedge clk) disable iff (!rst_n)
        autobaud_i |=> ($stable(tec_o) && $stable(rec_o)));

    // Remaining flags: sticky without clear (R8)
    assert_misc_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ((err_bit_o || err_form_o || err_ack_o) && !clr_i) |=>
        ($countones({err_bit_o, err_form_o, err_ack_o}) >=
         $countones($past({err_bit_o, err_form_o, err_ack_o}))));
endmodule

bind can_err_detect can_err_detect_chk u_chk (.*);

// File: tb/sim_can_err_detect.sv
module sim_can_err_detect;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       sample = 1'b0, rx = 1'b1, txb = 1'b1, txing = 1'b0, ab = 1'b0, clr = 1'b0;
    logic [3:0] fld = 4'd0;
    logic       e_crc, e_stuff, e_bit, e_form, e_ack, req, dom;
    logic [8:0] tec;
    logic [7:0] rec;

    int n_chk = 0, n_bad = 0, tec_m = 0, rec_m = 0, bs_cnt = 0;
    logic        bs_last = 1'b0;
    logic [14:0] crc_m = '0;
    logic        done = 1'b0;

    always #10 clk = ~clk;

    can_err_detect u0 (
        .clk(clk), .rst_n(rst_n), .sample_i(sample), .rx_bit_i(rx), .tx_bit_i(txb),
        .transmitting_i(txing), .field_i(fld), .autobaud_i(ab), .clr_i(clr),
        .err_crc_o(e_crc), .err_stuff_o(e_stuff), .err_bit_o(e_bit), .err_form_o(e_form),
        .err_ack_o(e_ack), .errframe_req_o(req), .bus_dom_o(dom), .tec_o(tec), .rec_o(rec)
    );

    // {ab,txing,tx,rx}_{field}_{crc,stuff,bit,form,ack}_{req,dom,0}
    localparam logic [15:0] VEC [16] = '{
        16'b0100_0001_00000_010,
        16'b0110_0010_00000_000,
        16'b0101_0010_00100_110,
        16'b0110_0011_00100_100,
        16'b0011_0011_00000_000,
        16'b0000_0101_10010_100,
        16'b0001_0101_10000_000,
        16'b0000_0111_00010_100,
        16'b0000_1000_00010_100,
        16'b0001_1000_00000_000,
        16'b0111_0110_00001_100,
        16'b0110_0110_00000_000,
        16'b0000_0000_00000_000,
        16'b1000_0111_00010_100,
        16'b1101_0010_00000_000,
        16'b0000_0000_00000_000
    };

    function automatic logic [14:0] crc_step(input logic [14:0] c, input logic b);
        logic fb;
        fb = b ^ c[14];
        return {c[13:0], 1'b0} ^ (fb ? 15'h4599 : 15'h0);
    endfunction

    task automatic check(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic drive_bit(input logic a, input logic t, input logic tb, input logic r,
                             input logic [3:0] f, input logic c);
        @(negedge clk);
        ab = a; txing = t; txb = tb; rx = r; fld = f; clr = c; sample = 1'b1;
        @(negedge clk);
        sample = 1'b0; clr = 1'b0;
    endtask

    task automatic clear_pulse();
        @(negedge clk); clr = 1'b1;
        @(negedge clk); clr = 1'b0;
    endtask

    // Receiver bit in the stuffed region, inserting stuff bits like a sender
    task automatic send_sbit(input logic [3:0] f, input logic b);
        if (bs_cnt == 5) begin
            drive_bit(1'b0, 1'b0, 1'b1, ~bs_last, f, 1'b0);
            bs_last = ~bs_last;
            bs_cnt  = 1;
        end
        drive_bit(1'b0, 1'b0, 1'b1, b, f, 1'b0);
        if (b == bs_last) bs_cnt++;
        else begin bs_cnt = 1; bs_last = b; end
    endtask

    function automatic int flags();
        return int'({e_crc, e_stuff, e_bit, e_form, e_ack});
    endfunction

    // Receive one frame; flip corrupts the last CRC bit
    task automatic rx_frame(input logic flip);
        logic [10:0] arb = 11'b00000111110;
        logic [7:0]  ctl = 8'hF0;
        clear_pulse();
        drive_bit(1'b0, 1'b0, 1'b1, 1'b0, 4'd1, 1'b0);
        bs_cnt = 1; bs_last = 1'b0; crc_m = crc_step(15'h0, 1'b0);
        for (int i = 10; i >= 0; i--) begin crc_m = crc_step(crc_m, arb[i]); send_sbit(4'd2, arb[i]); end
        for (int i = 7; i >= 0; i--) begin crc_m = crc_step(crc_m, ctl[i]); send_sbit(4'd3, ctl[i]); end
        for (int i = 14; i >= 0; i--) send_sbit(4'd4, crc_m[i] ^ (flip && i == 0));
        if (bs_cnt == 5) drive_bit(1'b0, 1'b0, 1'b1, ~bs_last, 4'd4, 1'b0);
        drive_bit(1'b0, 1'b0, 1'b1, 1'b1, 4'd5, 1'b0);
        if (flip) rec_m += 1;
        check("R5 CRC verdict (R2 stuff bits excluded)", flags(), flip ? 5'b10000 : 5'b00000);
        check("R7 no request for CRC error", int'(req), 0);
        @(negedge clk); fld = 4'd6; txing = 1'b0; txb = 1'b1;
        #1 check("R11 receiver acknowledge drive", int'(dom), flip ? 0 : 1);
        drive_bit(1'b0, 1'b0, 1'b1, 1'b0, 4'd6, 1'b0);
        drive_bit(1'b0, 1'b0, 1'b1, 1'b1, 4'd7, 1'b0);
        for (int i = 0; i < 7; i++) drive_bit(1'b0, 1'b0, 1'b1, 1'b1, 4'd8, 1'b0);
        check("R9 receive counter after frame", int'(rec), rec_m);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check("R1 flags after reset", flags(), 0);
        check("R1 request after reset", int'(req), 0);
        check("R1 drive after reset", int'(dom), 0);
        check("R1 counters after reset", int'(tec) + int'(rec), 0);

        // Vector table: R3 R4 R5 R6 R7 R8 R9 R10 R11
        for (int i = 0; i < 16; i++) begin
            logic [15:0] v;
            v = VEC[i];
            clear_pulse();
            drive_bit(v[15], v[14], v[13], v[12], v[11:8], 1'b0);
            if (|v[7:3] && !v[15]) begin
                if (v[14]) tec_m += 8; else rec_m += 1;
            end
            check($sformatf("R3/R4/R6/R10 flags vec %0d", i), flags(), int'(v[7:3]));
            check($sformatf("R7 request vec %0d", i), int'(req), int'(v[2]));
            check($sformatf("R11 drive vec %0d", i), int'(dom), int'(v[1]));
            check($sformatf("R9 tec vec %0d", i), int'(tec), tec_m);
            check($sformatf("R9 rec vec %0d", i), int'(rec), rec_m);
        end

        // Good frame with stuff bits, then acknowledge suppressed in autobaud
        rx_frame(1'b0);
        @(negedge clk); fld = 4'd6; txing = 1'b0; txb = 1'b1; ab = 1'b1;
        #1 check("R10 no acknowledge in autobaud", int'(dom), 0);
        @(negedge clk); ab = 1'b0;
        #1 check("R10 acknowledge back after autobaud", int'(dom), 1);

        // Corrupted CRC
        rx_frame(1'b1);

        // R2 stuff error on the sixth equal level
        clear_pulse();
        drive_bit(1'b0, 1'b0, 1'b1, 1'b0, 4'd1, 1'b0);
        for (int i = 0; i < 4; i++) drive_bit(1'b0, 1'b0, 1'b1, 1'b0, 4'd2, 1'b0);
        check("R2 no stuff error after five", flags(), 0);
        drive_bit(1'b0, 1'b0, 1'b1, 1'b0, 4'd2, 1'b0);
        rec_m += 1;
        check("R2 stuff error on sixth", flags(), 5'b01000);
        check("R7 request after stuff error", int'(req), 1);
        check("R9 rec after stuff error", int'(rec), rec_m);

        // R8 clear and detection in one strobe
        drive_bit(1'b0, 1'b0, 1'b1, 1'b0, 4'd7, 1'b1);
        rec_m += 1;
        check("R8 detection wins over clear", flags(), 5'b00010);
        check("R9 R10 counting resumed", int'(rec), rec_m);
        clear_pulse();
        check("R8 clear pulse", flags(), 0);
        check("R9 tec final", int'(tec), tec_m);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule